// File: doc/BRIEF.md
# Four-Bank Vector Register File with Paired Writes

This block is a vector register file that serves two operations issued together in one cycle. Registers sit in four banks, and the low two bits of a register index pick its bank. Each bank has three read ports, one for each source role (source 0, source 1, source 2). Reads of different roles may hit the same bank in the same cycle. Two reads of the same role may not. Each operation also brings one write port, so the file takes up to two writes per cycle.

Storage is split into an even-index half and an odd-index half. Each half therefore needs only one write port, provided the two destinations differ in parity. Upstream scheduling is expected to keep to the port and parity rules. The file still detects a violation and raises an error flag. When that happens, the offending reads return zero and an equal-parity write pair is discarded.

Read data is registered and appears one cycle after the address. A write lands at the end of its cycle, so a read in the same cycle as a write to that register returns the earlier contents.

Top module: `vrf_dual_issue`

## Requirements
- R1: After reset every read data output and `misuse_err` are zero, and every register reads as zero until written.
- R2: An enabled read returns the addressed register on its data output one clock edge after the address is presented. A read whose enable is low returns zero on that output.
- R3: The bank of a register is its index bits [1:0]. Reads of different roles (source 0, source 1, source 2) that address the same bank in one cycle are all served with correct data and raise no error.
- R4: When both operations enable the same role and their addresses have equal bits [1:0], both reads of that role return zero and `misuse_err` is 1 one edge later. Reads of the other roles in that cycle are unaffected.
- R5: Two reads of the same role on different banks are both served with correct data.
- R6: A read of a register that either operation writes in the same cycle returns the value held before the write. A read in the following cycle returns the new value.
- R7: Two writes in one cycle whose destination indices differ in bit 0 both take effect.
- R8: Two writes in one cycle whose destination indices share bit 0 are both discarded, and `misuse_err` is 1 one edge later.
- R9: A lone write from either operation takes effect, whatever the parity of its index.
- R10: `misuse_err` is 0 one edge after any cycle with no same-role bank clash and no equal-parity write pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opa_s0_addr | input | ADDR_W | Operation A source-0 register index |
| opa_s0_en | input | 1 | Operation A source-0 read enable |
| opa_s1_addr | input | ADDR_W | Operation A source-1 register index |
| opa_s1_en | input | 1 | Operation A source-1 read enable |
| opa_s2_addr | input | ADDR_W | Operation A source-2 register index |
| opa_s2_en | input | 1 | Operation A source-2 read enable |
| opa_wr_addr | input | ADDR_W | Operation A destination index |
| opa_wr_data | input | DATA_W | Operation A write data |
| opa_wr_en | input | 1 | Operation A write enable |
| opb_s0_addr | input | ADDR_W | Operation B source-0 register index |
| opb_s0_en | input | 1 | Operation B source-0 read enable |
| opb_s1_addr | input | ADDR_W | Operation B source-1 register index |
| opb_s1_en | input | 1 | Operation B source-1 read enable |
| opb_s2_addr | input | ADDR_W | Operation B source-2 register index |
| opb_s2_en | input | 1 | Operation B source-2 read enable |
| opb_wr_addr | input | ADDR_W | Operation B destination index |
| opb_wr_data | input | DATA_W | Operation B write data |
| opb_wr_en | input | 1 | Operation B write enable |
| opa_s0_data | output | DATA_W | Operation A source-0 read data |
| opa_s1_data | output | DATA_W | Operation A source-1 read data |
| opa_s2_data | output | DATA_W | Operation A source-2 read data |
| opb_s0_data | output | DATA_W | Operation B source-0 read data |
| opb_s1_data | output | DATA_W | Operation B source-1 read data |
| opb_s2_data | output | DATA_W | Operation B source-2 read data |
| misuse_err | output | 1 | Port clash or equal-parity write pair in the previous cycle |

## Verification
The bench sweeps every register index through each role. For each role it pairs every index with a same-bank partner, so a design that decodes the bank from the wrong bits, or zeroes the wrong role, returns data where zero is due, or the reverse. It writes all 1024 ordered destination pairs. A design that lets one write of an equal-parity pair through, or drops a legal pair, leaves register contents that the final readback exposes. In the same sweep, reads aimed at the register being written catch a file that forwards new data instead of returning the old value.

// File: rtl/vrf_pkg.sv
// Shared constants for the dual-issue register file.
// Assumes exactly two operations and three source roles per operation.
package vrf_pkg;
    localparam int NUM_OPS   = 2;
    localparam int NUM_ROLES = 3;
    localparam int BANK_BITS = 2;
    localparam int NUM_RD    = NUM_OPS * NUM_ROLES;

    typedef enum logic [1:0] {
        ROLE_S0 = 2'd0,
        ROLE_S1 = 2'd1,
        ROLE_S2 = 2'd2
    } src_role_e;
endpackage

// File: rtl/vrf_port_arbiter.sv
// Detects two reads of one source role that land on the same bank.
// Assumes the bank is given by the low BANK_BITS bits of the index.
module vrf_port_arbiter
    import vrf_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_en,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_en,
    output logic              clash
);
    // Same role, both enabled, same bank: one dedicated port cannot serve both.
    always_comb begin
        clash = a_en && b_en &&
                (a_addr[BANK_BITS-1:0] == b_addr[BANK_BITS-1:0]);
    end
endmodule

// File: rtl/vrf_write_steer.sv
// Routes the two write requests to the even and odd storage halves.
// Assumes legal pairs differ in index parity; an equal-parity pair is dropped.
module vrf_write_steer #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    localparam int HALF_W = ADDR_W - 1
) (
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_data,
    input  logic              b_we,
    output logic              even_we,
    output logic [HALF_W-1:0] even_idx,
    output logic [DATA_W-1:0] even_data,
    output logic              odd_we,
    output logic [HALF_W-1:0] odd_idx,
    output logic [DATA_W-1:0] odd_data,
    output logic              parity_clash
);
    // Flag a pair that would need two write ports on one half.
    always_comb begin
        parity_clash = a_we && b_we && (a_addr[0] == b_addr[0]);
    end

    // Steer each surviving write to the half selected by its index bit 0.
    always_comb begin
        even_we   = 1'b0;
        even_idx  = '0;
        even_data = '0;
        odd_we    = 1'b0;
        odd_idx   = '0;
        odd_data  = '0;
        if (!parity_clash) begin
            if (a_we) begin
                if (a_addr[0]) begin
                    odd_we    = 1'b1;
                    odd_idx   = a_addr[ADDR_W-1:1];
                    odd_data  = a_data;
                end else begin
                    even_we   = 1'b1;
                    even_idx  = a_addr[ADDR_W-1:1];
                    even_data = a_data;
                end
            end
            if (b_we) begin
                if (b_addr[0]) begin
                    odd_we    = 1'b1;
                    odd_idx   = b_addr[ADDR_W-1:1];
                    odd_data  = b_data;
                end else begin
                    even_we   = 1'b1;
                    even_idx  = b_addr[ADDR_W-1:1];
                    even_data = b_data;
                end
            end
        end
    end
endmodule

// File: rtl/vrf_half_store.sv
// One parity half of the register file: a single write port and NUM_RD
// combinational read ports. Cleared to zero by synchronous reset.
module vrf_half_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int NUM_RD = 6,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [IDX_W-1:0]              widx,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx,
    output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Storage update: clear on reset, otherwise one write at the clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Read ports see the contents from before this cycle's write.
    for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
        assign rd_data[k] = mem[rd_idx[k]];
    end

    // R7/R9: a write issued to this half is held in the addressed entry.
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/vrf_read_stage.sv
// Output register for one read port: picks the half by index parity and
// forces zero for a disabled or clashing read.
module vrf_read_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              kill,
    input  logic              odd_sel,
    input  logic [DATA_W-1:0] even_word,
    input  logic [DATA_W-1:0] odd_word,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] picked;

    // Select the half holding the register, or zero when not served.
    always_comb begin
        if (!en || kill) begin
            picked = '0;
        end else if (odd_sel) begin
            picked = odd_word;
        end else begin
            picked = even_word;
        end
    end

    // Register the read result one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= picked;
        end
    end
endmodule

// File: rtl/vrf_dual_issue.sv
// Four-bank register file for two co-issued operations. Each operation
// has three role-dedicated reads and one write per cycle. Upstream logic
// is assumed to avoid same-role bank clashes and equal-parity write
// pairs; any violation is flagged on misuse_err and suppressed.
module vrf_dual_issue
    import vrf_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 32,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] opa_s0_addr,
    input  logic              opa_s0_en,
    input  logic [ADDR_W-1:0] opa_s1_addr,
    input  logic              opa_s1_en,
    input  logic [ADDR_W-1:0] opa_s2_addr,
    input  logic              opa_s2_en,
    input  logic [ADDR_W-1:0] opa_wr_addr,
    input  logic [DATA_W-1:0] opa_wr_data,
    input  logic              opa_wr_en,
    input  logic [ADDR_W-1:0] opb_s0_addr,
    input  logic              opb_s0_en,
    input  logic [ADDR_W-1:0] opb_s1_addr,
    input  logic              opb_s1_en,
    input  logic [ADDR_W-1:0] opb_s2_addr,
    input  logic              opb_s2_en,
    input  logic [ADDR_W-1:0] opb_wr_addr,
    input  logic [DATA_W-1:0] opb_wr_data,
    input  logic              opb_wr_en,
    output logic [DATA_W-1:0] opa_s0_data,
    output logic [DATA_W-1:0] opa_s1_data,
    output logic [DATA_W-1:0] opa_s2_data,
    output logic [DATA_W-1:0] opb_s0_data,
    output logic [DATA_W-1:0] opb_s1_data,
    output logic [DATA_W-1:0] opb_s2_data,
    output logic              misuse_err
);
    localparam int HALF_REGS = NUM_REGS / 2;
    localparam int HALF_W    = ADDR_W - 1;

    logic [ADDR_W-1:0] rd_addr [NUM_OPS][NUM_ROLES];
    logic              rd_en   [NUM_OPS][NUM_ROLES];
    logic [DATA_W-1:0] rd_q    [NUM_OPS][NUM_ROLES];
    logic [NUM_ROLES-1:0] role_clash;

    logic [NUM_RD-1:0][HALF_W-1:0] rd_idx;
    logic [NUM_RD-1:0][DATA_W-1:0] even_rd;
    logic [NUM_RD-1:0][DATA_W-1:0] odd_rd;

    logic              even_we, odd_we, parity_clash;
    logic [HALF_W-1:0] even_idx, odd_idx;
    logic [DATA_W-1:0] even_data, odd_data;

    // Gather the read requests into role-indexed arrays.
    always_comb begin
        rd_addr[0][ROLE_S0] = opa_s0_addr;  rd_en[0][ROLE_S0] = opa_s0_en;
        rd_addr[0][ROLE_S1] = opa_s1_addr;  rd_en[0][ROLE_S1] = opa_s1_en;
        rd_addr[0][ROLE_S2] = opa_s2_addr;  rd_en[0][ROLE_S2] = opa_s2_en;
        rd_addr[1][ROLE_S0] = opb_s0_addr;  rd_en[1][ROLE_S0] = opb_s0_en;
        rd_addr[1][ROLE_S1] = opb_s1_addr;  rd_en[1][ROLE_S1] = opb_s1_en;
        rd_addr[1][ROLE_S2] = opb_s2_addr;  rd_en[1][ROLE_S2] = opb_s2_en;
    end

    // One clash detector per source role.
    for (genvar r = 0; r < NUM_ROLES; r++) begin : g_arb
        vrf_port_arbiter #(.ADDR_W(ADDR_W)) u_arb (
            .a_addr (rd_addr[0][r]),
            .a_en   (rd_en[0][r]),
            .b_addr (rd_addr[1][r]),
            .b_en   (rd_en[1][r]),
            .clash  (role_clash[r])
        );
    end

    vrf_write_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_steer (
        .a_addr       (opa_wr_addr),
        .a_data       (opa_wr_data),
        .a_we         (opa_wr_en),
        .b_addr       (opb_wr_addr),
        .b_data       (opb_wr_data),
        .b_we         (opb_wr_en),
        .even_we      (even_we),
        .even_idx     (even_idx),
        .even_data    (even_data),
        .odd_we       (odd_we),
        .odd_idx      (odd_idx),
        .odd_data     (odd_data),
        .parity_clash (parity_clash)
    );

    // Per-port read index within a half, and the output register stage.
    for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
        for (genvar r = 0; r < NUM_ROLES; r++) begin : g_role
            localparam int K = o * NUM_ROLES + r;
            assign rd_idx[K] = rd_addr[o][r][ADDR_W-1:1];
            vrf_read_stage #(.DATA_W(DATA_W)) u_rs (
                .clk       (clk),
                .rst_n     (rst_n),
                .en        (rd_en[o][r]),
                .kill      (role_clash[r]),
                .odd_sel   (rd_addr[o][r][0]),
                .even_word (even_rd[K]),
                .odd_word  (odd_rd[K]),
                .q         (rd_q[o][r])
            );
        end
    end

    vrf_half_store #(.DATA_W(DATA_W), .DEPTH(HALF_REGS), .NUM_RD(NUM_RD)) u_even (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (even_we),
        .widx    (even_idx),
        .wdata   (even_data),
        .rd_idx  (rd_idx),
        .rd_data (even_rd)
    );

    vrf_half_store #(.DATA_W(DATA_W), .DEPTH(HALF_REGS), .NUM_RD(NUM_RD)) u_odd (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (odd_we),
        .widx    (odd_idx),
        .wdata   (odd_data),
        .rd_idx  (rd_idx),
        .rd_data (odd_rd)
    );

    // Error flag: registered alongside the read data it qualifies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            misuse_err <= 1'b0;
        end else begin
            misuse_err <= (|role_clash) || parity_clash;
        end
    end

    assign opa_s0_data = rd_q[0][ROLE_S0];
    assign opa_s1_data = rd_q[0][ROLE_S1];
    assign opa_s2_data = rd_q[0][ROLE_S2];
    assign opb_s0_data = rd_q[1][ROLE_S0];
    assign opb_s1_data = rd_q[1][ROLE_S1];
    assign opb_s2_data = rd_q[1][ROLE_S2];

    // R2: a disabled read yields zero on the next edge.
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !opb_s2_en |=> (opb_s2_data == '0));

    // R4: same-role bank clash zeroes both reads of that role and flags.
    a_r4_s0_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (opa_s0_en && opb_s0_en && (opa_s0_addr[1:0] == opb_s0_addr[1:0]))
        |=> (opa_s0_data == '0 && opb_s0_data == '0 && misuse_err));

    a_r4_s1_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (opa_s1_en && opb_s1_en && (opa_s1_addr[1:0] == opb_s1_addr[1:0]))
        |=> (opa_s1_data == '0 && opb_s1_data == '0 && misuse_err));

    a_r4_s2_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (opa_s2_en && opb_s2_en && (opa_s2_addr[1:0] == opb_s2_addr[1:0]))
        |=> (opa_s2_data == '0 && opb_s2_data == '0 && misuse_err));

    // R8: an equal-parity write pair raises the error flag.
    a_r8_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (opa_wr_en && opb_wr_en && (opa_wr_addr[0] == opb_wr_addr[0]))
        |=> misuse_err);
endmodule

// File: tb/vrf_dual_issue_test.sv
`timescale 1ns/1ps
module vrf_dual_issue_test;
    localparam int DW = 16;
    localparam int NR = 32;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [AW-1:0] ra [2][3];
    logic          re [2][3];
    logic [AW-1:0] wa [2];
    logic [DW-1:0] wd [2];
    logic          we [2];
    logic [DW-1:0] rq [2][3];
    logic          err;

    logic [DW-1:0] model [NR];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    vrf_dual_issue #(.DATA_W(DW), .NUM_REGS(NR)) uut (
        .clk(clk), .rst_n(rst_n),
        .opa_s0_addr(ra[0][0]), .opa_s0_en(re[0][0]),
        .opa_s1_addr(ra[0][1]), .opa_s1_en(re[0][1]),
        .opa_s2_addr(ra[0][2]), .opa_s2_en(re[0][2]),
        .opa_wr_addr(wa[0]), .opa_wr_data(wd[0]), .opa_wr_en(we[0]),
        .opb_s0_addr(ra[1][0]), .opb_s0_en(re[1][0]),
        .opb_s1_addr(ra[1][1]), .opb_s1_en(re[1][1]),
        .opb_s2_addr(ra[1][2]), .opb_s2_en(re[1][2]),
        .opb_wr_addr(wa[1]), .opb_wr_data(wd[1]), .opb_wr_en(we[1]),
        .opa_s0_data(rq[0][0]), .opa_s1_data(rq[0][1]), .opa_s2_data(rq[0][2]),
        .opb_s0_data(rq[1][0]), .opb_s1_data(rq[1][1]), .opb_s2_data(rq[1][2]),
        .misuse_err(err)
    );

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                         input string tag, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        for (int o = 0; o < 2; o++) begin
            for (int r = 0; r < 3; r++) begin
                ra[o][r] = '0;
                re[o][r] = 1'b0;
            end
            wa[o] = '0;
            wd[o] = '0;
            we[o] = 1'b0;
        end
    endtask

    // Apply the current inputs for one cycle and check every output.
    task automatic step(input string tag);
        logic [DW-1:0] exp_q [2][3];
        bit cl [3];
        bit wclash;
        bit exp_err;
        for (int r = 0; r < 3; r++)
            cl[r] = re[0][r] && re[1][r] && (ra[0][r][1:0] == ra[1][r][1:0]);
        for (int o = 0; o < 2; o++)
            for (int r = 0; r < 3; r++)
                exp_q[o][r] = (!re[o][r] || cl[r]) ? '0 : model[ra[o][r]];
        wclash = we[0] && we[1] && (wa[0][0] == wa[1][0]);
        exp_err = cl[0] || cl[1] || cl[2] || wclash;
        @(posedge clk);
        if (!wclash) begin
            if (we[0]) model[wa[0]] = wd[0];
            if (we[1]) model[wa[1]] = wd[1];
        end
        @(negedge clk);
        for (int o = 0; o < 2; o++)
            for (int r = 0; r < 3; r++)
                check(rq[o][r], exp_q[o][r], tag, $sformatf("op%0d role%0d", o, r));
        check({15'd0, err}, {15'd0, exp_err}, tag, "misuse_err");
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) model[i] = '0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every register reads zero.
        step("R1");
        for (int i = 0; i < NR; i++) begin
            idle();
            ra[0][0] = AW'(i); re[0][0] = 1'b1;
            step("R1");
        end

        // R7 R10: fill the file with legal even/odd write pairs.
        for (int i = 0; i < NR; i += 2) begin
            idle();
            we[0] = 1'b1; wa[0] = AW'(i);     wd[0] = DW'(i * 16'h0101 ^ 16'h5A3C);
            we[1] = 1'b1; wa[1] = AW'(i + 1); wd[1] = DW'((i + 1) * 16'h0101 ^ 16'h5A3C);
            step("R7");
        end

        // R2 R5 R10: all six ports, same role on different banks.
        for (int i = 0; i < NR; i++) begin
            idle();
            ra[0][0] = AW'(i);     ra[1][0] = AW'(i + 1);
            ra[0][1] = AW'(i + 1); ra[1][1] = AW'(i + 3);
            ra[0][2] = AW'(i + 2); ra[1][2] = AW'(i + 4);
            for (int o = 0; o < 2; o++)
                for (int r = 0; r < 3; r++) re[o][r] = 1'b1;
            step("R5");
        end

        // R3: three roles all on bank 0 (index bits [1:0] = 0).
        idle();
        ra[0][0] = 5'd4; ra[0][1] = 5'd8; ra[0][2] = 5'd12;
        re[0][0] = 1'b1; re[0][1] = 1'b1; re[0][2] = 1'b1;
        ra[1][0] = 5'd1; re[1][0] = 1'b1;
        step("R3");

        // R2: disabled reads return zero even with addresses set.
        idle();
        ra[0][0] = 5'd3; ra[1][1] = 5'd9; ra[1][2] = 5'd17;
        step("R2");

        // R4: same-role same-bank clash for every role and index.
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < NR; i++) begin
                idle();
                ra[0][r] = AW'(i);     re[0][r] = 1'b1;
                ra[1][r] = AW'(i + 8); re[1][r] = 1'b1;
                ra[0][(r + 1) % 3] = AW'(i + 1); re[0][(r + 1) % 3] = 1'b1;
                ra[1][(r + 2) % 3] = AW'(i + 2); re[1][(r + 2) % 3] = 1'b1;
                step("R4");
            end
        end

        // R6: read returns the old value during a write, new value after.
        idle();
        ra[0][0] = 5'd5; re[0][0] = 1'b1;
        ra[1][1] = 5'd6; re[1][1] = 1'b1;
        we[1] = 1'b1; wa[1] = 5'd5; wd[1] = 16'hBEEF;
        we[0] = 1'b1; wa[0] = 5'd6; wd[0] = 16'hCAFE;
        step("R6");
        idle();
        ra[0][0] = 5'd5; re[0][0] = 1'b1;
        ra[1][1] = 5'd6; re[1][1] = 1'b1;
        step("R6");

        // R8: equal-parity pair is dropped and flagged.
        idle();
        we[0] = 1'b1; wa[0] = 5'd2; wd[0] = 16'h1111;
        we[1] = 1'b1; wa[1] = 5'd4; wd[1] = 16'h2222;
        step("R8");
        idle();
        ra[0][0] = 5'd2; re[0][0] = 1'b1;
        ra[1][0] = 5'd4; re[1][0] = 1'b1;
        ra[0][1] = 5'd4; re[0][1] = 1'b1;
        step("R8");

        // R9: lone writes of each parity from each operation.
        idle();
        we[0] = 1'b1; wa[0] = 5'd7; wd[0] = 16'h7777;
        step("R9");
        idle();
        we[1] = 1'b1; wa[1] = 5'd10; wd[1] = 16'hA0A0;
        step("R9");
        idle();
        ra[0][2] = 5'd7; re[0][2] = 1'b1;
        ra[1][2] = 5'd10; re[1][2] = 1'b1;
        step("R9");

        // R7 R8 R6: every ordered destination pair, reading the targets.
        for (int x = 0; x < NR; x++) begin
            for (int y = 0; y < NR; y++) begin
                idle();
                we[0] = 1'b1; wa[0] = AW'(x); wd[0] = DW'(x * 37 + y * 1000 + 1);
                we[1] = 1'b1; wa[1] = AW'(y); wd[1] = DW'(x * 911 + y * 13 + 7);
                ra[0][0] = AW'(y); re[0][0] = 1'b1;
                ra[1][1] = AW'(x); re[1][1] = 1'b1;
                step((x % 2) == (y % 2) ? "R8" : "R7");
            end
        end

        // R7: final readback of the whole file.
        for (int i = 0; i < NR; i++) begin
            idle();
            ra[1][0] = AW'(i); re[1][0] = 1'b1;
            step("R7");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule